// File: doc/BRIEF.md
# Memory-to-Peripheral Single-Channel DMA Engine

This block moves one contiguous chunk of data between memory and a peripheral register over a simple request/grant memory port. Software programs it through a small register file: a global word that arms the engine, a channel control word that starts, pauses or aborts a transfer, a configuration word with beat width, fixed-address flags, interrupt enables and a status field, and the source and destination address registers.

Each beat is a read at the source address followed by a write of the same data to the destination address. Beats are grouped into bursts of 4, 8 or 16. The transfer length is programmed as the number of bursts minus one. Either side can be held at a fixed address, which suits a peripheral data register. The address registers, the remaining-burst count and the in-burst beat index update while the transfer runs, so software can read progress at any time. Completion or a bus error sets a status code and can raise the interrupt line. Software acknowledges it by writing zero to the status field.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: A write to the control word with bit 31 set starts a transfer only when the channel is idle and the global word (offset 0x00) has bit 31 set. Otherwise no memory access happens and control bit 31 reads 0. Control bit 31 reads 1 exactly while a transfer is running or paused.
- R3: A transfer moves (count+1) x beats x width bytes. The count is control bits 15:0. Beats come from burst code control bits 23:20, where 0xF gives 16 beats, 0xD gives 8 and 0xB gives 4. Width comes from configuration bits 27:26, where 0 gives 1 byte, 1 gives 2 bytes and 2 gives 4 bytes. `mem_size` carries that width code.
- R4: Each beat is a read of the source address, then a write of the data just read to the destination address. Each side's address advances by the width after every completed beat. Configuration bit 25 holds the source fixed and bit 24 holds the destination fixed.
- R5: During a transfer the source (0x18) and destination (0x1C) registers read the current addresses. Control bits 15:0 read the remaining bursts minus one. Control bits 19:16 read the beats left in the current burst minus one.
- R6: `mem_req` stays high with a stable address and direction until `mem_gnt` is seen, unless the transfer is aborted.
- R7: After the last beat completes, status (configuration bits 18:16) becomes 1 and the channel returns to idle.
- R8: `mem_err` together with a grant stops the transfer with status 2. A start with an unknown burst code or with width code 3 sets status 2 and makes no access.
- R9: `irq` is high when status is 1 and the completion enable (configuration bit 19) is set, or when status is 2 and the error enable (configuration bit 20) is set. Writing zero to the status field clears it; writing a nonzero value leaves it unchanged. A start also clears it.
- R10: Control bit 30 (pause) stops the engine after the beat in progress completes. Clearing it resumes from the same addresses and counts.
- R11: Writing the control word with bit 31 clear while a transfer runs stops it before any further access, leaves the status unchanged, and leaves the addresses at the last completed beat.
- R12: While the channel is enabled, writes to the address registers and the configuration word are ignored, and a control write changes only the pause and enable bits.
- R13: Register offsets are 0x00 global, 0x10 control, 0x14 configuration, 0x18 source and 0x1C destination. All other offsets read zero. Control bits 28:24 and 29, and configuration bits 31:28, 23:21 and 15:0, are stored and read back with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| mem_err | input | 1 | Error response, valid with grant |
| irq | output | 1 | Channel interrupt |

## Verification
The bench sweeps every width code against every burst code and every combination of the two fixed-address flags. It checks each granted access against an address computed from the beat number, which catches a wrong step size, a fixed side that drifts, or burst codes decoded to the wrong beat count. A pause is held to land on the last beat of a burst, where a design that reloads or decrements its counters at the wrong moment would show the wrong remaining count or beat index, or would lose a beat on resume. An abort is issued and a bus error is injected while an access is pending. These catch a design that keeps issuing accesses after the stop, advances an address for a beat that never completed, or reports the wrong status code.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          irq
);
  localparam logic [3:0] BT16 = 4'hF, BT8 = 4'hD, BT4 = 4'hB;
  localparam logic [2:0] ST_DONE = 3'd1, ST_ERR = 3'd2;
  localparam logic [5:0] A_GLB = 6'h00, A_CTL = 6'h10, A_CFG = 6'h14,
                         A_SA = 6'h18, A_DA = 6'h1C;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_HOLD} state_t;
  state_t state;

  logic          gen_q, pause_q, trig_q;
  logic [4:0]    src_q;
  logic [3:0]    bt_q, beat_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    hi_q, mode_q, wc_q;
  logic          fs_q, fd_q, ei_q, ci_q;
  logic [2:0]    misc_q, stat_q;
  logic [15:0]   lo_q;
  logic [AW-1:0] sa_q, da_q;
  logic [DW-1:0] buf_q;

  function automatic logic [3:0] last_idx(input logic [3:0] bt);
    case (bt)
      BT16:    return 4'd15;
      BT8:     return 4'd7;
      default: return 4'd3;
    endcase
  endfunction

  logic wr_glb, wr_ctl, wr_cfg, wr_sa, wr_da;
  assign wr_glb = reg_we && reg_addr == A_GLB;
  assign wr_ctl = reg_we && reg_addr == A_CTL;
  assign wr_cfg = reg_we && reg_addr == A_CFG;
  assign wr_sa  = reg_we && reg_addr == A_SA;
  assign wr_da  = reg_we && reg_addr == A_DA;

  logic busy, start, abort, codes_ok, fault, last_beat, last_all;
  logic [2:0] wbytes;
  assign busy      = state != S_IDLE;
  assign start     = wr_ctl && reg_wdata[31] && !busy && gen_q;
  assign abort     = wr_ctl && !reg_wdata[31] && busy;
  assign codes_ok  = (reg_wdata[23:20] == BT16 || reg_wdata[23:20] == BT8 ||
                      reg_wdata[23:20] == BT4) && wc_q != 2'd3;
  assign fault     = mem_req && mem_gnt && mem_err;
  assign last_beat = beat_q == 4'd0;
  assign last_all  = last_beat && cnt_q == '0;
  assign wbytes    = 3'd1 << wc_q;

  assign mem_req   = state == S_RD || state == S_WR;
  assign mem_we    = state == S_WR;
  assign mem_addr  = (state == S_WR) ? da_q : sa_q;
  assign mem_size  = wc_q;
  assign mem_wdata = buf_q;
  assign irq       = (stat_q == ST_DONE && ci_q) || (stat_q == ST_ERR && ei_q);

  always_comb begin
    case (reg_addr)
      A_GLB:   reg_rdata = {gen_q, 31'b0};
      A_CTL:   reg_rdata = {busy, pause_q, trig_q, src_q, bt_q, beat_q, 16'(cnt_q)};
      A_CFG:   reg_rdata = {hi_q, mode_q, wc_q, fs_q, fd_q, misc_q, ei_q, ci_q, stat_q, lo_q};
      A_SA:    reg_rdata = 32'(sa_q);
      A_DA:    reg_rdata = 32'(da_q);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      gen_q   <= 1'b0;
      pause_q <= 1'b0;
      trig_q  <= 1'b0;
      src_q   <= '0;
      bt_q    <= '0;
      beat_q  <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
      mode_q  <= '0;
      wc_q    <= '0;
      fs_q    <= 1'b0;
      fd_q    <= 1'b0;
      misc_q  <= '0;
      ei_q    <= 1'b0;
      ci_q    <= 1'b0;
      stat_q  <= '0;
      lo_q    <= '0;
      sa_q    <= '0;
      da_q    <= '0;
      buf_q   <= '0;
    end else begin
      if (wr_glb) gen_q <= reg_wdata[31];
      if (wr_ctl) begin
        pause_q <= reg_wdata[30];
        if (!busy) begin
          trig_q <= reg_wdata[29];
          src_q  <= reg_wdata[28:24];
          bt_q   <= reg_wdata[23:20];
          cnt_q  <= reg_wdata[CW-1:0];
        end
      end
      if (wr_cfg && !busy) begin
        hi_q   <= reg_wdata[31:30];
        mode_q <= reg_wdata[29:28];
        wc_q   <= reg_wdata[27:26];
        fs_q   <= reg_wdata[25];
        fd_q   <= reg_wdata[24];
        misc_q <= reg_wdata[23:21];
        ei_q   <= reg_wdata[20];
        ci_q   <= reg_wdata[19];
        lo_q   <= reg_wdata[15:0];
        if (reg_wdata[18:16] == 3'd0) stat_q <= 3'd0;
      end
      if (wr_sa && !busy) sa_q <= reg_wdata[AW-1:0];
      if (wr_da && !busy) da_q <= reg_wdata[AW-1:0];

      case (state)
        S_IDLE: begin
          if (start) begin
            if (codes_ok) begin
              stat_q <= 3'd0;
              beat_q <= last_idx(reg_wdata[23:20]);
              state  <= reg_wdata[30] ? S_HOLD : S_RD;
            end else begin
              stat_q <= ST_ERR;
            end
          end
        end
        S_RD: begin
          if (abort) state <= S_IDLE;
          else if (fault) begin
            stat_q <= ST_ERR;
            state  <= S_IDLE;
          end else if (mem_gnt) begin
            buf_q <= mem_rdata;
            state <= S_WR;
          end
        end
        S_WR: begin
          if (abort) state <= S_IDLE;
          else if (fault) begin
            stat_q <= ST_ERR;
            state  <= S_IDLE;
          end else if (mem_gnt) begin
            if (!fs_q) sa_q <= sa_q + AW'(wbytes);
            if (!fd_q) da_q <= da_q + AW'(wbytes);
            if (last_all) begin
              stat_q <= ST_DONE;
              state  <= S_IDLE;
            end else begin
              if (last_beat) begin
                cnt_q  <= cnt_q - 1'b1;
                beat_q <= last_idx(bt_q);
              end else begin
                beat_q <= beat_q - 1'b1;
              end
              state <= pause_q ? S_HOLD : S_RD;
            end
          end
        end
        default: begin
          if (abort) state <= S_IDLE;
          else if (!pause_q) state <= S_RD;
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6

  AST_FIXED_DST_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fd_q) |=> (!busy || da_q == $past(da_q))); // R4

  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q))); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy) || $past(wr_cfg) || $past(wr_ctl))); // R9

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && !busy) |=> !busy); // R2
endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_gnt = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  int nb = 0, acc = 0, cyc = 0;
  int base_nb = 0, base_acc = 0, err_at = -1, hold_beat = 0;
  bit stall_on = 0, hold_on = 0, fs = 0, fd = 0, finished = 0;
  logic [31:0] sa0 = 0, da0 = 0, last_rd = 0, exp_a = 0;
  int wb = 1, wcode = 0, rel = 0;
  logic g;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    g = 1'b1;
    if (stall_on && (cyc % 3 == 1)) g = 1'b0;
    cyc++;
    if (hold_on && mem_we && (nb - base_nb) == hold_beat) g = 1'b0;
    mem_gnt = g;
    mem_err = 1'b0;
    if (mem_req && g) begin
      rel = nb - base_nb;
      m_chk++;
      if (!mem_we) begin
        exp_a = sa0 + (fs ? 0 : rel * wb);
        if (mem_addr != exp_a || mem_size != 2'(wcode)) begin
          m_bad++;
          $display("FAIL R4 read address/size: got %h/%0d expected %h/%0d", mem_addr, mem_size, exp_a, wcode);
        end
        mem_rdata = mem_addr ^ 32'h5A5A_00FF;
        last_rd = mem_rdata;
      end else begin
        exp_a = da0 + (fd ? 0 : rel * wb);
        if (mem_addr != exp_a || mem_wdata != last_rd) begin
          m_bad++;
          $display("FAIL R4 write addr/data: got %h/%h expected %h/%h", mem_addr, mem_wdata, exp_a, last_rd);
        end
      end
      if (acc - base_acc == err_at) mem_err = 1'b1;
      else if (mem_we) nb++;
      acc++;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(int w, bit s, bit t, bit ei, bit ci, int st);
    return (32'd2 << 28) | (32'(w) << 26) | (32'(s) << 25) | (32'(t) << 24) |
           (32'(ei) << 20) | (32'(ci) << 19) | (32'(st) << 16);
  endfunction

  function automatic logic [31:0] ctlw(bit en, bit p, int bt, int cnt);
    return (32'(en) << 31) | (32'(p) << 30) | (32'(bt) << 20) | 32'(cnt[15:0]);
  endfunction

  task automatic setup(int w, bit s, bit t, logic [31:0] a, logic [31:0] b, bit ei, bit ci);
    wcode = w; wb = 1 << w; fs = s; fd = t; sa0 = a; da0 = b;
    base_nb = nb; base_acc = acc; err_at = -1;
    wr(6'h18, a);
    wr(6'h1C, b);
    wr(6'h14, cfgw(w, s, t, ei, ci, 0));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(6'h10, v);
      if (!v[31]) break;
    end
  endtask

  task automatic wait_cond_beat(int k);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #2;
      if (mem_req && mem_we && (nb - base_nb) == k) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bts [3] = '{4'hB, 4'hD, 4'hF};
    int nbs [3] = '{4, 8, 16};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(6'(a * 4), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    rd(6'h10, v); rd(6'h14, v); rd(6'h18, v); rd(6'h1C, v);
    check(v == 0 && !irq && !mem_req, "R1 idle outputs", {30'b0, irq, mem_req}, 0);

    // R2 global disable blocks start
    setup(2, 0, 0, 32'h100, 32'h200, 0, 1);
    wr(6'h10, ctlw(1, 0, 4'hB, 0));
    repeat (5) @(negedge clk);
    rd(6'h10, v);
    check(!v[31] && acc == base_acc, "R2 no start with global off", {v[31], 31'(acc - base_acc)}, 0);
    wr(6'h00, 32'h8000_0000);
    rd(6'h00, v);
    check(v == 32'h8000_0000, "R13 global word readback", v, 32'h8000_0000);

    // R3 R4 R5 R7 R9 sweep
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 3; b++)
        for (int fx = 0; fx < 4; fx++) begin
          bit ci;
          int tot;
          ci = (fx != 3);
          stall_on = (fx % 2 == 1);
          setup(w, fx[0], fx[1], 32'h2000 + 32'(fx << 8), 32'h4_0000, 0, ci);
          wr(6'h10, ctlw(1, 0, bts[b], 1));
          wait_idle();
          tot = 2 * nbs[b];
          check(nb - base_nb == tot, "R3 beat count", 32'(nb - base_nb), 32'(tot));
          rd(6'h18, v);
          check(v == sa0 + (fs ? 0 : tot * wb), "R5 final source", v, sa0 + (fs ? 0 : tot * wb));
          rd(6'h1C, v);
          check(v == da0 + (fd ? 0 : tot * wb), "R5 final destination", v, da0 + (fd ? 0 : tot * wb));
          rd(6'h14, v);
          check(v[18:16] == 3'd1, "R7 done status", 32'(v[18:16]), 1);
          check(irq == ci, "R9 irq by completion enable", 32'(irq), 32'(ci));
          wr(6'h14, cfgw(w, fx[0], fx[1], 0, ci, 0));
          check(irq == 0, "R9 ack clears irq", 32'(irq), 0);
        end
    stall_on = 0;

    // R10 R12 pause at a burst boundary, 4-byte, 8-beat, fixed destination
    setup(2, 0, 1, 32'h1000, 32'h8000_0040, 0, 1);
    hold_on = 1; hold_beat = 7;
    wr(6'h10, ctlw(1, 0, 4'hD, 2));
    wait_cond_beat(7);
    wr(6'h10, ctlw(1, 1, 4'hF, 16'h55));
    hold_on = 0;
    repeat (10) @(negedge clk);
    #2 check(!mem_req, "R10 paused no request", 32'(mem_req), 0);
    check(nb - base_nb == 8, "R10 beats before pause", 32'(nb - base_nb), 8);
    rd(6'h18, v);
    check(v == 32'h1020, "R10 source at pause", v, 32'h1020);
    rd(6'h1C, v);
    check(v == 32'h8000_0040, "R4 fixed destination at pause", v, 32'h8000_0040);
    rd(6'h10, v);
    check(v[15:0] == 1 && v[19:16] == 7 && v[31] && v[30], "R5 R12 count/beat while paused",
          {v[31:30], 10'b0, v[19:0]}, {2'b11, 10'b0, 4'd7, 16'd1});
    wr(6'h18, 32'hDEAD_0000);
    rd(6'h18, v);
    check(v == 32'h1020, "R12 address write ignored", v, 32'h1020);
    wr(6'h10, ctlw(1, 0, 4'hD, 2));
    wait_idle();
    check(nb - base_nb == 24, "R10 total beats after resume", 32'(nb - base_nb), 24);
    rd(6'h18, v);
    check(v == 32'h1060, "R10 final source", v, 32'h1060);
    rd(6'h1C, v);
    check(v == 32'h8000_0040, "R4 final fixed destination", v, 32'h8000_0040);
    check(irq == 1, "R9 irq after transfer", 32'(irq), 1);
    wr(6'h14, cfgw(2, 0, 1, 0, 1, 3));
    rd(6'h14, v);
    check(v[18:16] == 1 && irq, "R9 nonzero status write ignored", 32'(v[18:16]), 1);
    wr(6'h14, cfgw(2, 0, 1, 0, 1, 0));
    check(irq == 0, "R9 acknowledge", 32'(irq), 0);

    // R11 abort
    setup(0, 0, 0, 32'h3000, 32'h5000, 1, 1);
    hold_on = 1; hold_beat = 5;
    wr(6'h10, ctlw(1, 0, 4'hF, 3));
    wait_cond_beat(5);
    wr(6'h10, 32'h0);
    hold_on = 0;
    repeat (4) @(negedge clk);
    #2 check(!mem_req && !irq, "R11 abort stops", {30'b0, mem_req, irq}, 0);
    rd(6'h10, v);
    check(!v[31], "R11 enable reads 0", 32'(v[31]), 0);
    rd(6'h14, v);
    check(v[18:16] == 0, "R11 status unchanged", 32'(v[18:16]), 0);
    rd(6'h18, v);
    check(v == 32'h3005, "R11 source at abort", v, 32'h3005);

    // R8 bus error on read of beat 3
    setup(1, 0, 0, 32'h6000, 32'h7000, 1, 0);
    err_at = 6;
    wr(6'h10, ctlw(1, 0, 4'hB, 1));
    wait_idle();
    rd(6'h14, v);
    check(v[18:16] == 2, "R8 error status", 32'(v[18:16]), 2);
    check(irq == 1, "R9 error irq", 32'(irq), 1);
    rd(6'h18, v);
    check(v == 32'h6006, "R8 source at error", v, 32'h6006);
    wr(6'h14, cfgw(1, 0, 0, 1, 0, 0));

    // R8 invalid codes
    setup(2, 0, 0, 32'h100, 32'h200, 1, 1);
    wr(6'h10, ctlw(1, 0, 4'h3, 0));
    repeat (3) @(negedge clk);
    rd(6'h14, v);
    check(v[18:16] == 2 && acc == base_acc, "R8 bad burst code", {v[18:16], 29'(acc - base_acc)}, {3'd2, 29'd0});
    setup(3, 0, 0, 32'h100, 32'h200, 1, 1);
    wr(6'h10, ctlw(1, 0, 4'hD, 0));
    repeat (3) @(negedge clk);
    rd(6'h14, v);
    check(v[18:16] == 2 && acc == base_acc, "R8 bad width code", {v[18:16], 29'(acc - base_acc)}, {3'd2, 29'd0});

    // R13 stored fields and unmapped offset
    wr(6'h14, 32'hC0E0_ABCD);
    rd(6'h14, v);
    check(v == 32'hC0E0_ABCD, "R13 configuration readback", v, 32'hC0E0_ABCD);
    rd(6'h08, v);
    check(v == 0, "R13 unmapped offset", v, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end
endmodule